// File: doc/BRIEF.md
# Multiplexed Address/Data Byte Read Sequencer

This block runs one external read cycle on a 16-bit bus where address and data share lines. It fetches a single byte from an asynchronous memory or memory-mapped peripheral in 8-bit mode. A request carries a 16-bit address, a count of data cycles and a hold-cycle enable. The block then places the full address on the bus, latches it with an address strobe (ALE), releases the lower byte lanes and pulses the read strobe. It samples the returned byte when the read strobe rises and reports it with a one-cycle done pulse.

The block runs on a clock at twice the core rate, so one clock tick is half a core cycle and every bus edge falls on a half-core-cycle boundary. The pins are the strobes, the address outputs, and separate output enables for the upper and lower byte lanes. The bus pads are outside the block. One configuration input selects the ALE polarity.

Top module: `mux_rd_seq`

## Requirements
- R1: During and after reset, rd_n and wr_n are 1, both lane enables are 0, busy and done are 0, and ale sits at its inactive level.
- R2: A request is accepted on a clock edge where req_valid is 1 and the block is idle. busy is 1 from the next cycle. It returns to 0 in the cycle where done is 1.
- R3: From the cycle after acceptance, ad_out carries the full request address while its lane enable is set. Both lane enables are 1 for 5 ticks before ALE goes inactive: 1 tick before ALE becomes active, plus the ALE ticks.
- R4: ALE is active for exactly 4 ticks, starting 1 tick after the address is first driven.
- R5: The lower lane enable stays on for 1 tick after ALE goes inactive and is then 0 until the next request. It is never 1 while rd_n is 0.
- R6: rd_n falls 2 ticks after ALE goes inactive and stays 0 for 2×D ticks, where D is req_dcyc. A req_dcyc of 0 is handled as 1. ALE is never active while rd_n is 0.
- R7: The upper lane enable stays on for 1 tick after rd_n rises, or for 3 ticks when req_hold is 1. It then drops.
- R8: The byte on ad_in at the clock edge where rd_n rises is placed on rdata. done is 1 for exactly one cycle, in the cycle where the upper lane enable first drops.
- R9: With cfg_ale_low at 0, ALE is active high. With cfg_ale_low at 1, the ale pin is inverted. The setting applies from the next cycle and is meant to change only while idle.
- R10: wr_n stays 1 at all times.
- R11: A request made while busy is 1 has no effect on the cycle in progress: its address, timing and returned byte are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the core rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ale_low | input | 1 | 1 selects an active-low ale pin |
| req_valid | input | 1 | Read request |
| req_addr | input | 16 | Byte address to read |
| req_dcyc | input | 4 | Read strobe width in core cycles (0 acts as 1) |
| req_hold | input | 1 | Adds one core cycle of upper-address hold |
| busy | output | 1 | A read cycle is in progress |
| done | output | 1 | One-cycle pulse: rdata is valid |
| rdata | output | 8 | Byte returned by the last read |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, held high |
| ad_out | output | 16 | Address value for the shared lanes |
| ad_oe_hi | output | 1 | Output enable for lanes 15..8 |
| ad_oe_lo | output | 1 | Output enable for lanes 7..0 |
| ad_in | input | 8 | Bus value on lanes 7..0 |

## Verification
A wrong state or tick count in the sequencer shows at the pins within one tick: an ALE pulse of the wrong length, a read strobe that is too short or starts too late, or a lower-lane enable that overlaps the read. A lost latched address shows on ad_out within one tick of the enable. A capture on the wrong edge shows as the wrong byte in rdata when done pulses. Because the memory model drives the bus only while rd_n is 0, a late capture reads the released bus. A request that should have been ignored but was taken shows either as a changed address or as a second done pulse.

// File: rtl/mux_rd_pkg.sv
package mux_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ALE,
    ST_GAP,
    ST_READ,
    ST_TAIL
  } rd_state_e;

  // Pin intent for the next cycle, before polarity and registering
  typedef struct packed {
    logic ale_act;
    logic rd_act;
    logic oe_hi;
    logic oe_lo;
  } pin_ctl_t;

endpackage

// File: rtl/mux_rd_ctrl.sv
module mux_rd_ctrl
  import mux_rd_pkg::*;
#(
  parameter int CYC_W           = 4,
  parameter int SETUP_TICKS     = 1,
  parameter int ALE_TICKS       = 4,
  parameter int ADDR_HOLD_TICKS = 1,
  parameter int RD_DELAY_TICKS  = 2,
  parameter int TAIL_TICKS      = 1,
  parameter int HOLD_TICKS      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CYC_W-1:0] req_dcyc,
  input  logic             req_hold,
  output logic             busy,
  output logic             accept,
  output logic             cap_en,
  output logic             done_set,
  output pin_ctl_t         ctl_nxt
);

  localparam int CNT_W = CYC_W + 2;
  localparam logic [CNT_W-1:0] SETUP_M1 = CNT_W'(SETUP_TICKS - 1);
  localparam logic [CNT_W-1:0] ALE_M1   = CNT_W'(ALE_TICKS - 1);
  localparam logic [CNT_W-1:0] GAP_M1   = CNT_W'(RD_DELAY_TICKS - 1);
  localparam logic [CNT_W-1:0] LO_LAST  = CNT_W'(RD_DELAY_TICKS - ADDR_HOLD_TICKS);
  localparam logic [CNT_W-1:0] TAIL_M1  = CNT_W'(TAIL_TICKS - 1);
  localparam logic [CNT_W-1:0] HTAIL_M1 = CNT_W'(TAIL_TICKS + HOLD_TICKS - 1);

  rd_state_e        state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CYC_W-1:0] dcyc_q;
  logic             hold_q;
  logic [CNT_W-1:0] read_m1;
  logic             last;

  assign last    = (cnt_q == '0);
  assign read_m1 = {1'b0, dcyc_q, 1'b0} - CNT_W'(1);
  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign cap_en  = (state_q == ST_READ) && last;
  assign done_set = (state_q == ST_TAIL) && last;
  assign busy    = (state_q != ST_IDLE);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q - CNT_W'(1);
    case (state_q)
      ST_IDLE: begin
        cnt_n = '0;
        if (req_valid) begin
          state_n = ST_SETUP;
          cnt_n   = SETUP_M1;
        end
      end
      ST_SETUP: if (last) begin state_n = ST_ALE;  cnt_n = ALE_M1;  end
      ST_ALE:   if (last) begin state_n = ST_GAP;  cnt_n = GAP_M1;  end
      ST_GAP:   if (last) begin state_n = ST_READ; cnt_n = read_m1; end
      ST_READ:  if (last) begin
                  state_n = ST_TAIL;
                  cnt_n   = hold_q ? HTAIL_M1 : TAIL_M1;
                end
      ST_TAIL:  if (last) begin state_n = ST_IDLE; cnt_n = '0; end
      default:  begin state_n = ST_IDLE; cnt_n = '0; end
    endcase
  end

  always_comb begin
    ctl_nxt.ale_act = (state_n == ST_ALE);
    ctl_nxt.rd_act  = (state_n == ST_READ);
    ctl_nxt.oe_hi   = (state_n != ST_IDLE);
    ctl_nxt.oe_lo   = (state_n == ST_SETUP) || (state_n == ST_ALE) ||
                      ((state_n == ST_GAP) && (cnt_n >= LO_LAST));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dcyc_q  <= CYC_W'(1);
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      if (accept) begin
        dcyc_q <= (req_dcyc == '0) ? CYC_W'(1) : req_dcyc;
        hold_q <= req_hold;
      end
    end
  end

endmodule

// File: rtl/mux_rd_pins.sv
module mux_rd_pins
  import mux_rd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_ale_low,
  input  pin_ctl_t          ctl_nxt,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [ADDR_W-1:0] ad_out,
  output logic              oe_hi,
  output logic              oe_lo
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= cfg_ale_low;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      ad_out <= '0;
      oe_hi  <= 1'b0;
      oe_lo  <= 1'b0;
    end else begin
      ale    <= ctl_nxt.ale_act ^ cfg_ale_low;
      rd_n   <= ~ctl_nxt.rd_act;
      wr_n   <= 1'b1;
      oe_hi  <= ctl_nxt.oe_hi;
      oe_lo  <= ctl_nxt.oe_lo;
      if (accept) ad_out <= req_addr;
    end
  end

endmodule

// File: rtl/mux_rd_capture.sv
module mux_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              done_set,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= done_set;
      if (cap_en) rdata <= ad_in;
    end
  end

endmodule

// File: rtl/mux_rd_seq.sv
module mux_rd_seq
  import mux_rd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CYC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ale_low,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CYC_W-1:0]  req_dcyc,
  input  logic              req_hold,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [ADDR_W-1:0] ad_out,
  output logic              ad_oe_hi,
  output logic              ad_oe_lo,
  input  logic [DATA_W-1:0] ad_in
);

  logic     accept, cap_en, done_set;
  pin_ctl_t ctl_nxt;

  mux_rd_ctrl #(.CYC_W(CYC_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_dcyc (req_dcyc),
    .req_hold (req_hold),
    .busy     (busy),
    .accept   (accept),
    .cap_en   (cap_en),
    .done_set (done_set),
    .ctl_nxt  (ctl_nxt)
  );

  mux_rd_pins #(.ADDR_W(ADDR_W)) u_pins (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .req_addr   (req_addr),
    .cfg_ale_low(cfg_ale_low),
    .ctl_nxt    (ctl_nxt),
    .ale        (ale),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .ad_out     (ad_out),
    .oe_hi      (ad_oe_hi),
    .oe_lo      (ad_oe_lo)
  );

  mux_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (cap_en),
    .done_set(done_set),
    .ad_in   (ad_in),
    .rdata   (rdata),
    .done    (done)
  );

endmodule

// File: rtl/mux_rd_seq_chk.sv
module mux_rd_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_ale_low,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rdata,
  input logic              ale,
  input logic              rd_n,
  input logic              wr_n,
  input logic              ad_oe_hi,
  input logic              ad_oe_lo,
  input logic [DATA_W-1:0] ad_in
);

  a_r10_wr_high: assert property (@(posedge clk) disable iff (rst)
    wr_n);

  a_r5_no_lane_fight: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe_lo);

  a_r6_ale_idle_in_read: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> (ale == cfg_ale_low));

  a_r3_lo_within_hi: assert property (@(posedge clk) disable iff (rst)
    ad_oe_lo |-> ad_oe_hi);

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !ad_oe_hi));

  a_r8_capture_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_n) |-> (rdata == $past(ad_in)));

  a_r8_done_after_read: assert property (@(posedge clk) disable iff (rst)
    done |-> rd_n);

endmodule

bind mux_rd_seq mux_rd_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_ale_low(cfg_ale_low),
  .busy       (busy),
  .done       (done),
  .rdata      (rdata),
  .ale        (ale),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .ad_oe_hi   (ad_oe_hi),
  .ad_oe_lo   (ad_oe_lo),
  .ad_in      (ad_in)
);

// File: tb/mux_rd_seq_test.sv
module mux_rd_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_ale_low = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_dcyc = '0;
  logic        req_hold = 1'b0;
  logic        busy, done, ale, rd_n, wr_n, ad_oe_hi, ad_oe_lo;
  logic [7:0]  rdata;
  logic [15:0] ad_out;
  logic [7:0]  ad_in;
  logic [15:0] cur_addr = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mux_rd_seq uut (
    .clk(clk), .rst(rst), .cfg_ale_low(cfg_ale_low),
    .req_valid(req_valid), .req_addr(req_addr), .req_dcyc(req_dcyc),
    .req_hold(req_hold), .busy(busy), .done(done), .rdata(rdata),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
    .ad_oe_hi(ad_oe_hi), .ad_oe_lo(ad_oe_lo), .ad_in(ad_in)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  // memory model: drives lanes 7..0 only while the read strobe is low
  assign ad_in = (!rd_n) ? mem_byte(cur_addr) : 8'h00;

  // expected {ale_act, rd_n, wr_n, oe_hi, oe_lo, busy, done} k edges after accept
  function automatic logic [6:0] exp_pins(input int k, input int d, input int t);
    logic a, r, h, l, b, dn;
    a = 0; r = 1; h = 1; l = 0; b = 1; dn = 0;
    if (k <= 4) l = 1;
    if (k >= 1 && k <= 4) a = 1;
    if (k == 5) l = 1;
    if (k >= 7 && k <= 6 + 2*d) r = 0;
    if (k == 7 + 2*d + t) begin h = 0; b = 0; dn = 1; end
    return {a, r, 1'b1, h, l, b, dn};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_read(input logic [15:0] addr, input logic [3:0] dcyc,
                          input logic hold, input bit junk);
    int d, t, n;
    logic [6:0] e;
    string atag;
    d = (dcyc == 0) ? 1 : int'(dcyc);
    t = hold ? 3 : 1;
    n = 7 + 2*d + t;
    atag = cfg_ale_low ? "R9" : "R4";
    @(negedge clk);
    cur_addr  = addr;
    req_addr  = addr;
    req_dcyc  = dcyc;
    req_hold  = hold;
    req_valid = 1'b1;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      e = exp_pins(k, d, t);
      chk(ale == (e[6] ^ cfg_ale_low), atag, ale, e[6] ^ cfg_ale_low);
      chk(rd_n == e[5], (dcyc == 0) ? "R6 (zero count)" : "R6", rd_n, e[5]);
      chk(wr_n == e[4], "R10", wr_n, e[4]);
      chk(ad_oe_hi == e[3], "R7", ad_oe_hi, e[3]);
      chk(ad_oe_lo == e[2], "R5", ad_oe_lo, e[2]);
      chk(busy == e[1], "R2", busy, e[1]);
      chk(done == e[0], "R8 done", done, e[0]);
      if (e[3]) chk(ad_out[15:8] == addr[15:8], junk ? "R11 hi" : "R3 hi",
                    ad_out[15:8], addr[15:8]);
      if (e[2]) chk(ad_out[7:0] == addr[7:0], junk ? "R11 lo" : "R3 lo",
                    ad_out[7:0], addr[7:0]);
      if (k == n) begin
        chk(rdata == mem_byte(addr), junk ? "R11 data" : "R8 data",
            rdata, mem_byte(addr));
        req_valid = 1'b0;
      end else if (junk) begin
        req_valid = 1'($urandom);
        req_addr  = 16'($urandom);
        req_dcyc  = 4'($urandom);
        req_hold  = 1'($urandom);
      end else begin
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R11 no extra cycle", {busy, done}, 0);
  endtask

  task automatic set_polarity(input logic low);
    @(negedge clk);
    cfg_ale_low = low;
    @(negedge clk);
    chk(ale == low, "R9 idle level", ale, low);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state (checked while reset is held)
    chk(rd_n == 1 && wr_n == 1, "R1 strobes", {rd_n, wr_n}, 3);
    chk(ad_oe_hi == 0 && ad_oe_lo == 0, "R1 enables", {ad_oe_hi, ad_oe_lo}, 0);
    chk(busy == 0 && done == 0, "R1 status", {busy, done}, 0);
    chk(ale == 0, "R1 ale", ale, 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(rd_n == 1 && busy == 0 && ale == 0, "R1 after release", {rd_n, busy, ale}, 4);

    // directed corners
    run_read(16'h1234, 4'd0,  1'b0, 0);   // R6 zero count acts as one
    run_read(16'hBEEF, 4'd1,  1'b1, 0);   // R7 with hold
    run_read(16'hFFFF, 4'd15, 1'b1, 0);   // R6 longest strobe
    run_read(16'h00A0, 4'd3,  1'b0, 1);   // R11 requests while busy
    set_polarity(1'b1);                   // R9 active-low ale
    run_read(16'h5A5A, 4'd2,  1'b0, 0);
    run_read(16'hC3E1, 4'd4,  1'b1, 1);
    set_polarity(1'b0);

    // constrained random
    for (int i = 0; i < 30; i++) begin
      if (($urandom % 5) == 0) set_polarity(1'($urandom));
      run_read(16'($urandom), 4'($urandom), 1'($urandom), (($urandom % 3) == 0));
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule